// File: doc/BRIEF.md
# SPI Boot Receive Word Packer

This block is the receive side of an SPI slave used while a device boots. An external host drives the serial clock, the data line and an active-low select. The host sends host words that are 8, 16 or 32 bits wide, and the block rebuilds them into 32-bit words. The design runs on a faster system clock that oversamples the serial pins. When a 32-bit word is complete, the block offers it on a valid/ready stream to the memory-write stage that follows.

Narrow host words are packed least-significant word first. The first host word received goes into the lowest bits of the output word. The serial stream has no gaps, so the bit after the last bit of one 32-bit word is the first bit of the next. The block counts the words that the downstream stage accepts. It raises a done flag once the boot image, 256 words by default, has been taken.

Back-pressure rules: a word that is offered stays on `out_data`, with `out_valid` high, until it is taken in a cycle where `out_ready` is high. The serial source cannot be stalled. A word that completes while the previous word is still held is therefore dropped, and the sticky `overflow` flag records the loss. A word that completes in the same cycle that the held word is taken is not a loss: it loads without raising the flag.

Top module: `spi_boot_packer`

## Requirements
- R1: `host_width` selects the host word size: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 or 2'b11 = 32 bits. One output word needs exactly four, two or one host words respectively.
- R2: Host words fill the output word lowest slot first. With 8-bit host words 0x66, 0x55, 0x44, 0x33 the output is 0x33445566. With 16-bit host words 0x5566, 0x3344 the output is also 0x33445566.
- R3: Within each host word, bits arrive MSB first. A bit is taken on a rising edge of `spi_sclk`, and only while `spi_cs_n` is low. Rising edges while `spi_cs_n` is high have no effect.
- R4: The stream is continuous. Three back-to-back 32-bit words take exactly 96 serial clocks and produce three output words.
- R5: When `spi_cs_n` goes high, any partly received host word and any partly packed output word are thrown away. The next selection starts a fresh word.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: A word that completes while a held word is not taken in that cycle is dropped, and `overflow` is set. `overflow` stays set until reset. A completion in the same cycle as an acceptance loads the new word and does not set `overflow`.
- R8: `word_count` counts accepted words. `boot_done` goes high when `word_count` reaches BOOT_WORDS (256). Once 256 words have been offered, further completions are dropped and `out_valid` stays low.
- R9: With the default two-stage input synchronizer, `out_valid` rises on the fifth system clock edge after `spi_sclk` goes high with the last bit of a word, provided no word is held.
- R10: After reset, `out_valid`, `word_count`, `boot_done` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host; idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| host_width | input | 2 | Host word size; must be stable while selected |
| out_valid | output | 1 | A packed word is offered |
| out_ready | input | 1 | The downstream stage takes the offered word |
| out_data | output | 32 | Packed word |
| word_count | output | 9 | Number of accepted words |
| boot_done | output | 1 | The full boot image has been accepted |
| overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
Two events can land on the same clock edge: a new word completing in the packer, and the downstream stage taking the held word. Because the bench knows each serial edge it drives, it predicts the exact edge on which each word completes. It raises `out_ready` for that one edge only, while an earlier word is being held. The per-cycle reference model then expects the new word on `out_data` and `overflow` still clear. The companion case, where `out_ready` stays low through the completion, must instead set the flag and keep the older word.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    HW_BYTE  = 2'b00,
    HW_HALF  = 2'b01,
    HW_FULL  = 2'b10,
    HW_FULL2 = 2'b11
  } host_width_e;

  function automatic logic [5:0] host_bits(input logic [1:0] sel);
    case (sel)
      HW_BYTE: host_bits = 6'd8;
      HW_HALF: host_bits = 6'd16;
      default: host_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [1:0] last_slot(input logic [1:0] sel);
    case (sel)
      HW_BYTE: last_slot = 2'd3;
      HW_HALF: last_slot = 2'd1;
      default: last_slot = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic rise_o,
  output logic mosi_o,
  output logic cs_hi_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES:0]  sclk_q;
  logic [LAST:0]    mosi_q;
  logic [LAST:0]    cs_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q[g] <= 1'b0;
          mosi_q[g] <= 1'b0;
          cs_q[g]   <= 1'b1;
        end else begin
          sclk_q[g] <= (g == 0) ? sclk_i : sclk_q[(g == 0) ? 0 : g - 1];
          mosi_q[g] <= (g == 0) ? mosi_i : mosi_q[(g == 0) ? 0 : g - 1];
          cs_q[g]   <= (g == 0) ? cs_n_i : cs_q[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q[STAGES] <= 1'b0;
    else        sclk_q[STAGES] <= sclk_q[LAST];
  end

  assign rise_o  = sclk_q[LAST] & ~sclk_q[STAGES];
  assign mosi_o  = mosi_q[LAST];
  assign cs_hi_o = cs_q[LAST];
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              cs_hi_i,
  input  logic [1:0]        width_i,
  output logic              host_vld_o,
  output logic [WORD_W-1:0] host_word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [5:0]        nbits;
  logic              at_last;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    nbits   = host_bits(width_i);
    at_last = ({1'b0, bit_cnt} == (nbits - 6'd1));
    shifted = {shreg[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      host_vld_o  <= 1'b0;
      host_word_o <= '0;
    end else begin
      host_vld_o <= 1'b0;
      if (cs_hi_i) begin
        bit_cnt <= '0;
      end else if (rise_i) begin
        shreg <= shifted;
        if (at_last) begin
          bit_cnt     <= '0;
          host_vld_o  <= 1'b1;
          host_word_o <= shifted;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi_i |=> (bit_cnt == '0)); // R5
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
  import spi_boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi_i,
  input  logic [1:0]        width_i,
  input  logic              host_vld_i,
  input  logic [WORD_W-1:0] host_word_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned QTR  = WORD_W / 4;
  localparam int unsigned HALF = WORD_W / 2;

  logic [1:0]        slot;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;

  always_comb begin
    case (width_i)
      HW_BYTE: merged = {host_word_i[QTR-1:0], acc[WORD_W-1:QTR]};
      HW_HALF: merged = {host_word_i[HALF-1:0], acc[WORD_W-1:HALF]};
      default: merged = host_word_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot       <= '0;
      acc        <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (cs_hi_i) begin
        slot <= '0;
      end else if (host_vld_i) begin
        acc <= merged;
        if (slot == last_slot(width_i)) begin
          slot       <= '0;
          word_vld_o <= 1'b1;
          word_o     <= merged;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  AST_PACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o); // R1
  AST_DESELECT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi_i |=> (slot == '0)); // R5
endmodule

// File: rtl/spi_out_stage.sv
module spi_out_stage
  import spi_boot_pkg::*;
#(
  parameter int unsigned BOOT_WORDS = 256,
  parameter int unsigned CNT_W      = $clog2(BOOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BOOT_WORDS);

  logic [CNT_W-1:0] issued;
  logic             take;

  assign take   = valid_o & ready_i;
  assign done_o = (count_o == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      count_o <= '0;
      issued  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (take) begin
        valid_o <= 1'b0;
        count_o <= count_o + 1'b1;
      end
      if (word_vld_i && (issued != LIMIT)) begin
        if (valid_o && !ready_i) begin
          ovf_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= word_i;
          issued  <= issued + 1'b1;
        end
      end
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (count_o == $past(count_o) + 1'b1)); // R8
endmodule

// File: rtl/spi_boot_packer.sv
module spi_boot_packer
  import spi_boot_pkg::*;
#(
  parameter int unsigned BOOT_WORDS  = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(BOOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  input  logic [1:0]        host_width,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  word_count,
  output logic              boot_done,
  output logic              overflow
);
  logic              rise, mosi_s, cs_hi;
  logic              host_vld, word_vld;
  logic [WORD_W-1:0] host_word, packed_word;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
    .cs_n_i(spi_cs_n), .rise_o(rise), .mosi_o(mosi_s), .cs_hi_o(cs_hi));

  spi_host_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_i(mosi_s), .cs_hi_i(cs_hi),
    .width_i(host_width), .host_vld_o(host_vld), .host_word_o(host_word));

  spi_word_packer u_pack (
    .clk(clk), .rst_n(rst_n), .cs_hi_i(cs_hi), .width_i(host_width),
    .host_vld_i(host_vld), .host_word_i(host_word),
    .word_vld_o(word_vld), .word_o(packed_word));

  spi_out_stage #(.BOOT_WORDS(BOOT_WORDS), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_i(packed_word),
    .ready_i(out_ready), .valid_o(out_valid), .data_o(out_data),
    .count_o(word_count), .done_o(boot_done), .ovf_o(overflow));
endmodule

// File: tb/spi_boot_packer_bench.sv
`timescale 1ns/1ps
module spi_boot_packer_bench;
  localparam int BOOT = 256;
  localparam int HALFP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [1:0] hw = 2'b10;
  logic out_ready = 1'b0;
  logic out_valid, boot_done, overflow;
  logic [31:0] out_data;
  logic [8:0] word_count;

  always #2.5 clk = ~clk;

  spi_boot_packer u_spi_boot_packer (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .host_width(hw), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .word_count(word_count), .boot_done(boot_done),
    .overflow(overflow));

  int checks = 0, errors = 0;
  int cyc = 0;
  int rmode = 0;
  int target = -1;
  int last_due = 0;

  logic [31:0] q_word[$];
  int          q_due[$];
  logic        m_valid, m_ovf;
  logic [31:0] m_data;
  int          m_count, m_issued;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reference model: compare, then step across the coming posedge.
  always @(negedge clk) begin
    bit rdy;
    case (rmode)
      0: rdy = 1'b0;
      1: rdy = 1'b1;
      2: rdy = (cyc % 3) != 0;
      default: rdy = (cyc + 1 == target);
    endcase
    out_ready = rdy;
    if (!rst_n) begin
      m_valid = 0; m_ovf = 0; m_data = '0; m_count = 0; m_issued = 0;
      q_word.delete(); q_due.delete();
    end else begin
      chk(out_valid == m_valid, "R6 out_valid", out_valid, m_valid);
      if (m_valid && out_valid) chk(out_data == m_data, "R2 out_data", out_data, m_data);
      chk(word_count == m_count, "R8 word_count", word_count, m_count);
      chk(boot_done == (m_count == BOOT), "R8 boot_done", boot_done, m_count == BOOT);
      chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
      if (m_valid && rdy) begin m_valid = 0; m_count++; end
      if (q_due.size() > 0 && q_due[0] == cyc + 1) begin
        logic [31:0] w;
        w = q_word.pop_front();
        void'(q_due.pop_front());
        if (m_issued != BOOT) begin
          if (m_valid) m_ovf = 1;
          else begin m_valid = 1; m_data = w; m_issued++; end
        end
      end
    end
  end

  task automatic send_bit(input logic b, input bit last, input logic [31:0] w);
    mosi = b;
    repeat (HALFP) @(negedge clk);
    sclk = 1'b1;
    if (last && !cs_n) begin
      q_word.push_back(w);
      q_due.push_back(cyc + 5);  // R9: five system edges to out_valid
      last_due = cyc + 5;
    end
    repeat (HALFP) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    int hb;
    hb = (hw == 2'b00) ? 8 : (hw == 2'b01) ? 16 : 32;
    for (int k = 0; k < 32 / hb; k++)
      for (int i = hb - 1; i >= 0; i--)
        send_bit(w[k*hb+i], (k == 32/hb - 1) && (i == 0), w);
  endtask

  task automatic select();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic deselect();
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask
  task automatic do_reset(input logic [1:0] w, input int mode);
    @(negedge clk); rst_n = 1'b0; hw = w; rmode = mode;
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask
  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && word_count == 0 && boot_done == 0 && overflow == 0,
        "R10 reset outputs", {out_valid, boot_done, overflow, word_count}, 0);
    rst_n = 1'b1;

    // R1 R4: three 32-bit words back to back, 96 serial clocks
    do_reset(2'b10, 1);
    select();
    send_word(32'h33445566); send_word(32'h778899AA); send_word(32'hDEADBEEF);
    deselect(); settle();
    chk(word_count == 3, "R4 three words from 96 clocks", word_count, 3);

    // R1 R2 R3: 8-bit host, bytes 0x66,0x55,0x44,0x33
    do_reset(2'b00, 1);
    select(); send_word(32'h33445566); send_word(32'h0180FE7F); deselect(); settle();
    chk(word_count == 2, "R1 byte host four per word", word_count, 2);
    chk(out_data == 32'h0180FE7F, "R2 byte packing", out_data, 32'h0180FE7F);

    // R1 R2: 16-bit host, 0x5566 then 0x3344
    do_reset(2'b01, 0);
    select(); send_word(32'h33445566); deselect(); settle();
    chk(out_valid && out_data == 32'h33445566, "R2 half packing", out_data, 32'h33445566);
    rmode = 1; settle();

    // R3: edges while deselected are ignored
    do_reset(2'b00, 1);
    for (int i = 0; i < 20; i++) send_bit(1'b1, i == 19, 32'hFFFFFFFF);
    settle();
    chk(word_count == 0 && !out_valid, "R3 deselected edges ignored", word_count, 0);
    select(); send_word(32'hA1B2C3D4); deselect(); settle();
    chk(word_count == 1 && out_data == 32'hA1B2C3D4, "R3 clean word after", out_data, 32'hA1B2C3D4);

    // R5: partial word discarded on deselect
    do_reset(2'b00, 1);
    select();
    for (int i = 0; i < 12; i++) send_bit(i[0], 1'b0, 0);
    deselect();
    select(); send_word(32'h12345678); deselect(); settle();
    chk(word_count == 1 && out_data == 32'h12345678, "R5 partial discarded", out_data, 32'h12345678);

    // R6 R7: overflow under back-pressure
    do_reset(2'b10, 0);
    select(); send_word(32'hCAFEF00D); send_word(32'h0BADC0DE); deselect(); settle();
    chk(overflow == 1, "R7 overflow set", overflow, 1);
    chk(out_valid && out_data == 32'hCAFEF00D, "R6 older word held", out_data, 32'hCAFEF00D);
    rmode = 1; settle();
    chk(word_count == 1 && overflow == 1, "R7 dropped word and sticky flag", word_count, 1);

    // R7: acceptance and completion on the same edge
    do_reset(2'b10, 0);
    select(); send_word(32'h11112222); send_word(32'h33334444);
    target = last_due; rmode = 3;
    deselect(); settle();
    chk(overflow == 0, "R7 same-edge no overflow", overflow, 0);
    chk(out_valid && out_data == 32'h33334444, "R7 same-edge new word", out_data, 32'h33334444);
    rmode = 1; settle();
    chk(word_count == 2, "R7 both words delivered", word_count, 2);

    // R8: full boot image, then extra word dropped
    do_reset(2'b10, 2);
    select();
    for (int i = 0; i < BOOT; i++) send_word(32'h5A5AA5A5 ^ (i * 32'h01010101));
    deselect(); settle();
    chk(boot_done == 1 && word_count == BOOT, "R8 done after image", word_count, BOOT);
    select(); send_word(32'hFFFF0000); deselect(); settle();
    chk(!out_valid && word_count == BOOT, "R8 extra word dropped", word_count, BOOT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule